// File: doc/BRIEF.md
# Two-Stage I2C SCL Prescaler

This block produces the timing base for an I2C bus engine from the peripheral clock. The first stage divides the peripheral clock by a small integer. It does not make a gated clock. It emits a one-cycle internal-clock enable once every `CDF+1` peripheral cycles. The second stage counts those enables over one SCL bit period of `8*SCGD + 20` enables, with a fixed offset of 20. Within each period it marks the SCL falling edge, the middle of the low half, the SCL rising edge and the middle of the high half, each with a one-cycle tick. It also drives the level that SCL should currently have.

Both divider fields arrive in one configuration byte, which is captured on a write strobe. Some settings are not allowed: a setting that would run the internal clock at or above the allowed maximum, and the reserved top SCL code. For these the block flags the setting as bad and stays idle. Both counters start again from zero on every configuration write and whenever the enable input is low. This gives the bus engine a known phase at the start of each transfer.

Top module: `i2c_scl_prescaler`

## Requirements
- R1: A write strobe captures the configuration byte. Bits [1:0] hold the first-stage field CDF and bits [7:2] hold the SCL field SCGD. `cfg_ok` reflects the captured byte from the following cycle, whether or not `en` is high.
- R2: `iclk_en` is a one-cycle pulse every CDF+1 peripheral cycles. The first pulse comes CDF+1 cycles after the restart cycle, which is cycle 0.
- R3: One SCL period spans P = 8*SCGD + 20 internal-clock enables. Ticks appear only in the cycle that follows an `iclk_en` pulse.
- R4: The low half lasts ceil(P/2) enables and the high half lasts the rest. `tick_fall` marks enable index 0 of a period and `tick_rise` marks index ceil(P/2). `scl_lvl` is 0 from the fall tick until the rise tick and 1 otherwise.
- R5: `tick_lmid` marks index floor(ceil(P/2)/2) and `tick_hmid` marks index ceil(P/2) + floor((P-ceil(P/2))/2). At most one tick is high in any cycle.
- R6: A setting is invalid if PCLK_HZ/(CDF+1) is at least IMAX_HZ, or if SCGD is above SCGD_TOP (62). With an invalid setting `cfg_ok` is 0, no enable or tick is produced, and `scl_lvl` stays 1.
- R7: A configuration write restarts both counters. The cycle after the write strobe is cycle 0 of the new timing, and no enable or tick appears in it.
- R8: While `en` is low, no enable or tick is produced and `scl_lvl` is 1. The cycle in which `en` returns high is cycle 0.
- R9: After reset the configuration byte is 0, the outputs are idle and `scl_lvl` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low holds and restarts both stages |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_byte | input | 8 | Configuration byte: [1:0] first divider, [7:2] SCL field |
| cfg_ok | output | 1 | Captured setting is usable |
| iclk_en | output | 1 | Internal-clock enable pulse |
| tick_fall | output | 1 | SCL falling-edge tick |
| tick_lmid | output | 1 | Middle of SCL low half |
| tick_rise | output | 1 | SCL rising-edge tick |
| tick_hmid | output | 1 | Middle of SCL high half |
| scl_lvl | output | 1 | Level SCL should currently have |

## Verification
The bench checks every cycle of two full periods for several divider pairs. This covers the smallest SCL field, the largest allowed SCL field and every valid first-stage divide. A design that used a plain N+1 divide or dropped the 20-cycle offset would put the rise tick in the wrong cycle, and so would one that started the first pulse one cycle early or late. Both invalid cases are checked: the over-speed internal clock and the reserved SCL code. A design that ignored either would emit enables where silence is expected. Rewriting the configuration mid-period and toggling `en` must each restart the phase from cycle 0; a design that kept the old count would tick at stale offsets.

// File: rtl/ipre_pkg.sv
package ipre_pkg;
    localparam int CDF_W   = 2;
    localparam int SCGD_W  = 6;
    localparam int CFG_W   = CDF_W + SCGD_W;
    localparam int PER_OFS = 20;
    localparam int PER_MAX = 8 * (2**SCGD_W - 1) + PER_OFS;
    localparam int CNT_W   = $clog2(PER_MAX + 1);

    typedef struct packed {
        logic [SCGD_W-1:0] scgd;
        logic [CDF_W-1:0]  cdf;
    } cfg_t;
endpackage

// File: rtl/ipre_decode.sv
module ipre_decode
    import ipre_pkg::*;
#(
    parameter int PCLK_HZ  = 33_000_000,
    parameter int IMAX_HZ  = 20_000_000,
    parameter int SCGD_TOP = 62
) (
    input  cfg_t              cfg,
    output logic [CDF_W-1:0]  cdf,
    output logic [SCGD_W-1:0] scgd,
    output logic              ok
);
    localparam int N_DIV = 2**CDF_W;

    logic [N_DIV-1:0] rate_ok;

    for (genvar g = 0; g < N_DIV; g++) begin : g_rate
        localparam bit RATE_FINE = (PCLK_HZ / (g + 1)) < IMAX_HZ;
        assign rate_ok[g] = RATE_FINE;
    end

    always_comb begin
        cdf  = cfg.cdf;
        scgd = cfg.scgd;
        ok   = rate_ok[cfg.cdf] && (int'(cfg.scgd) <= SCGD_TOP);
    end
endmodule

// File: rtl/ipre_stage1.sv
module ipre_stage1
    import ipre_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [CDF_W-1:0] cdf,
    output logic             ien
);
    typedef struct packed {
        logic [CDF_W-1:0] cnt;
        logic             pulse;
    } s1_t;

    s1_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (hold) begin
            s_d.cnt   = '0;
            s_d.pulse = 1'b0;
        end else begin
            s_d.pulse = (s_q.cnt == cdf);
            s_d.cnt   = (s_q.cnt == cdf) ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ien = s_q.pulse;
endmodule

// File: rtl/ipre_stage2.sv
module ipre_stage2
    import ipre_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              ien,
    input  logic [SCGD_W-1:0] scgd,
    output logic              tick_fall,
    output logic              tick_lmid,
    output logic              tick_rise,
    output logic              tick_hmid,
    output logic              scl_lvl
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fall;
        logic             lmid;
        logic             rise;
        logic             hmid;
        logic             lvl;
    } s2_t;

    s2_t s_d, s_q;

    logic [CNT_W-1:0] per, low_len, lmid_at, hmid_at;

    always_comb begin
        per     = CNT_W'({scgd, 3'b000}) + CNT_W'(PER_OFS);
        low_len = (per + 1'b1) >> 1;
        lmid_at = low_len >> 1;
        hmid_at = low_len + ((per - low_len) >> 1);
    end

    always_comb begin
        s_d      = s_q;
        s_d.fall = 1'b0;
        s_d.lmid = 1'b0;
        s_d.rise = 1'b0;
        s_d.hmid = 1'b0;
        if (hold) begin
            s_d.cnt = '0;
            s_d.lvl = 1'b1;
        end else if (ien) begin
            s_d.fall = (s_q.cnt == '0);
            s_d.lmid = (s_q.cnt == lmid_at);
            s_d.rise = (s_q.cnt == low_len);
            s_d.hmid = (s_q.cnt == hmid_at);
            if (s_q.cnt == '0)     s_d.lvl = 1'b0;
            if (s_q.cnt == low_len) s_d.lvl = 1'b1;
            s_d.cnt = (s_q.cnt == per - 1'b1) ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.lvl <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick_fall = s_q.fall;
    assign tick_lmid = s_q.lmid;
    assign tick_rise = s_q.rise;
    assign tick_hmid = s_q.hmid;
    assign scl_lvl   = s_q.lvl;
endmodule

// File: rtl/i2c_scl_prescaler.sv
module i2c_scl_prescaler
    import ipre_pkg::*;
#(
    parameter int PCLK_HZ  = 33_000_000,
    parameter int IMAX_HZ  = 20_000_000,
    parameter int SCGD_TOP = 62
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_byte,
    output logic             cfg_ok,
    output logic             iclk_en,
    output logic             tick_fall,
    output logic             tick_lmid,
    output logic             tick_rise,
    output logic             tick_hmid,
    output logic             scl_lvl
);
    cfg_t              cfg_d, cfg_q;
    logic [CDF_W-1:0]  cdf;
    logic [SCGD_W-1:0] scgd;
    logic              set_ok;
    logic              hold;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) cfg_d = cfg_t'(cfg_byte);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    ipre_decode #(
        .PCLK_HZ (PCLK_HZ),
        .IMAX_HZ (IMAX_HZ),
        .SCGD_TOP(SCGD_TOP)
    ) u_dec (
        .cfg (cfg_q),
        .cdf (cdf),
        .scgd(scgd),
        .ok  (set_ok)
    );

    assign hold   = !en || cfg_wr || !set_ok;
    assign cfg_ok = set_ok;

    ipre_stage1 u_s1 (
        .clk  (clk),
        .rst_n(rst_n),
        .hold (hold),
        .cdf  (cdf),
        .ien  (iclk_en)
    );

    ipre_stage2 u_s2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .ien      (iclk_en),
        .scgd     (scgd),
        .tick_fall(tick_fall),
        .tick_lmid(tick_lmid),
        .tick_rise(tick_rise),
        .tick_hmid(tick_hmid),
        .scl_lvl  (scl_lvl)
    );
endmodule

// File: rtl/ipre_chk.sv
module ipre_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic cfg_wr,
    input logic cfg_ok,
    input logic iclk_en,
    input logic tick_fall,
    input logic tick_lmid,
    input logic tick_rise,
    input logic tick_hmid,
    input logic scl_lvl
);
    // R5
    tick_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tick_fall, tick_lmid, tick_rise, tick_hmid}));

    // R3
    tick_after_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_fall || tick_lmid || tick_rise || tick_hmid) |-> $past(iclk_en));

    // R4
    fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_fall |-> !scl_lvl);

    // R4
    rise_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_rise |-> scl_lvl);

    // R6
    bad_cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |=> !iclk_en);

    // R7
    wr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (!iclk_en && !tick_fall && !tick_rise && scl_lvl));

    // R8
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!iclk_en && scl_lvl));
endmodule

bind i2c_scl_prescaler ipre_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .cfg_wr   (cfg_wr),
    .cfg_ok   (cfg_ok),
    .iclk_en  (iclk_en),
    .tick_fall(tick_fall),
    .tick_lmid(tick_lmid),
    .tick_rise(tick_rise),
    .tick_hmid(tick_hmid),
    .scl_lvl  (scl_lvl)
);

// File: tb/sim_i2c_scl_prescaler.sv
module sim_i2c_scl_prescaler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_byte = 8'h00;
    logic cfg_ok, iclk_en, tick_fall, tick_lmid, tick_rise, tick_hmid, scl_lvl;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    i2c_scl_prescaler u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_wr(cfg_wr), .cfg_byte(cfg_byte),
        .cfg_ok(cfg_ok), .iclk_en(iclk_en), .tick_fall(tick_fall),
        .tick_lmid(tick_lmid), .tick_rise(tick_rise), .tick_hmid(tick_hmid),
        .scl_lvl(scl_lvl)
    );

    // {expected cfg_ok, config byte}; 33 MHz clock, 20 MHz ceiling
    localparam logic [8:0] VEC [6] = '{
        {1'b1, 8'h01},   // div 2, scgd 0  -> P=20
        {1'b1, 8'h0E},   // div 3, scgd 3  -> P=44
        {1'b1, 8'h07},   // div 4, scgd 1  -> P=28
        {1'b1, 8'hF9},   // div 2, scgd 62 -> P=516
        {1'b0, 8'h14},   // div 1 -> 33 MHz internal, invalid
        {1'b0, 8'hFE}    // scgd 63 reserved, invalid
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] model(input int c, input int n1, input int p);
        int l, lm, hm, k, v;
        logic ien, f, a, r, b, lv;
        l  = (p + 1) / 2;
        lm = l / 2;
        hm = l + (p - l) / 2;
        ien = (c > 0) && (c % n1 == 0);
        f = 0; a = 0; r = 0; b = 0; lv = 1;
        if (c >= n1 + 1) begin
            k = (c - 1) / n1 - 1;
            v = k % p;
            if ((c - 1) % n1 == 0) begin
                f = (v == 0); a = (v == lm); r = (v == l); b = (v == hm);
            end
            lv = (v < l) ? 1'b0 : 1'b1;
        end
        return {ien, f, a, r, b, lv};
    endfunction

    function automatic logic [5:0] outs();
        return {iclk_en, tick_fall, tick_lmid, tick_rise, tick_hmid, scl_lvl};
    endfunction

    task automatic write_cfg(input logic [7:0] b);
        @(negedge clk);
        cfg_byte = b;
        cfg_wr   = 1'b1;
        @(negedge clk);
        cfg_wr   = 1'b0;
    endtask

    // called at the negedge of cycle 0
    task automatic run_valid(input logic [7:0] b, input int cycles, input string req);
        int n1, p;
        n1 = int'(b[1:0]) + 1;
        p  = 8 * int'(b[7:2]) + 20;
        for (int c = 0; c < cycles; c++) begin
            if (c > 0) @(negedge clk);
            chk(req, 32'(outs()), 32'(model(c, n1, p)));
        end
    endtask

    task automatic run_idle(input int cycles, input string req);
        for (int c = 0; c < cycles; c++) begin
            if (c > 0) @(negedge clk);
            chk(req, 32'(outs()), 32'(6'b000001));
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        chk("R9 outputs", 32'(outs()), 32'(6'b000001));
        chk("R9 cfg_ok", 32'(cfg_ok), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle after release", 32'(outs()), 32'(6'b000001));
        en = 1'b1;

        // table walk
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b;
            int n1, p;
            b  = VEC[i][7:0];
            n1 = int'(b[1:0]) + 1;
            p  = 8 * int'(b[7:2]) + 20;
            write_cfg(b);
            chk("R1 R6 cfg_ok", 32'(cfg_ok), 32'(VEC[i][8]));
            if (VEC[i][8]) run_valid(b, 2 * p * n1 + 8, "R2 R3 R4 R5 R7");
            else           run_idle(100, "R6 invalid quiet");
        end

        // R7: rewrite in the middle of a period restarts the phase
        write_cfg(8'h0E);
        run_valid(8'h0E, 37, "R7 before rewrite");
        write_cfg(8'h07);
        run_valid(8'h07, 2 * 28 * 4 + 8, "R7 after rewrite");

        // R8: enable low holds idle, then restarts at cycle 0
        write_cfg(8'h0E);
        run_valid(8'h0E, 50, "R8 before disable");
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        run_idle(20, "R8 disabled idle");
        @(negedge clk);
        en = 1'b1;
        run_valid(8'h0E, 2 * 44 * 3 + 8, "R8 restart");

        // R1: write while disabled loads the setting without running
        @(negedge clk);
        en = 1'b0;
        write_cfg(8'h05);
        chk("R1 cfg_ok while off", 32'(cfg_ok), 32'd1);
        run_idle(10, "R1 off after write");
        @(negedge clk);
        en = 1'b1;
        run_valid(8'h05, 2 * 28 * 2 + 8, "R1 R2 fields applied");

        // R6: move from valid to over-speed setting silences output
        write_cfg(8'h00);
        chk("R6 cfg_ok cdf0", 32'(cfg_ok), 32'd0);
        run_idle(30, "R6 over-speed idle");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule